// File: doc/BRIEF.md
# Dual-Width Serial Line Transmitter

This block turns parallel code groups into a single serial bit stream for a gigabit link. A parallel word of two 10-bit code groups is offered on `par_data`. A width selector decides whether the word carries one code group or two. Everything runs in the bit-clock domain. An internal bit counter wraps after the last bit of each word and raises `word_strb` for one cycle. In that cycle the block captures the offered word and its width into a holding stage. At the same edge it loads the previously held word into the shift register, so consecutive words leave back to back with no idle bit between them.

Within a code group the bits leave in order a through j, with the lowest-numbered input lane of the group sent first. In narrow mode only the upper lanes are used. In wide mode the lower group is sent in full and then the upper group. Two output-enable inputs either pass the serial data or force the line to a fixed low or high level.

Top module: `dws_serializer`

## Requirements
- R1: A synchronous reset clears the bit counter, the holding stage and the shift register. The first word after reset is treated as narrow and is all zeros. `word_strb` is therefore first high in the 10th cycle after reset is released.
- R2: While the current word is narrow, `word_strb` is high once every 10 cycles, in the cycle in which the word's last bit is on the line.
- R3: While the current word is wide, `word_strb` is high once every 20 cycles. No interval between strobes is anything other than 10 or 20 cycles.
- R4: A narrow word sends `par_data[10]` first and `par_data[19]` last, one bit per cycle.
- R5: A wide word sends `par_data[0]` first and `par_data[19]` last, one bit per cycle. Lanes 0 to 9 (the first group) go out before lanes 10 to 19.
- R6: In narrow mode, lanes 0 to 9 of `par_data` have no effect on `ser_out`.
- R7: The word on `par_data` in a cycle with `word_strb` high goes out starting in the cycle after the next `word_strb`. Words follow one another with no gap cycles.
- R8: `width_sel` is sampled only in a cycle with `word_strb` high, and it applies to the word captured in that same cycle (1 = wide, 0 = narrow). Changes in any other cycle have no effect.
- R9: Output-enable encoding on `oe[1:0]`: `2'b00` drives `ser_out` low, `2'b01` drives it high, and `oe[1]` = 1 drives the serial data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| width_sel | input | 1 | Word width for the word captured at the strobe: 1 = 20 bits, 0 = 10 bits |
| par_data | input | 20 | Parallel word, two 10-bit code groups |
| oe | input | 2 | Output-enable pair controlling the line state |
| ser_out | output | 1 | Serial line output |
| word_strb | output | 1 | High during the last bit of the current word; the word is captured in this cycle |

## Verification
The bench keeps its own bit queues for the word on the line and the word being held, and compares every cycle. It toggles `width_sel` at random on every cycle and changes the lower lanes during narrow traffic. A design that sampled the width outside the strobe, or that leaked lanes 0 to 9 into a narrow word, would send a wrongly sized word or wrong bits. The bench also checks that the first word after reset is ten zero bits. An off-by-one in the load or wrap logic would show up as a repeated or dropped bit at a word seam. All four output-enable codes are applied while data is flowing. A swapped encoding would force the wrong idle level or pass data while the line should be held.

// File: rtl/dws_pkg.sv
package dws_pkg;
   typedef enum logic [1:0] {
      LINE_LOW  = 2'b00,
      LINE_HIGH = 2'b01,
      LINE_DATA = 2'b10,
      LINE_DAT2 = 2'b11
   } line_mode_e;

   function automatic int unsigned cnt_bits(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/dws_bit_counter.sv
module dws_bit_counter #(
   parameter int unsigned CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] last_idx,
   output logic             wrap
);
   logic [CNT_W-1:0] cnt_q;

   assign wrap = (cnt_q == last_idx);

   always_ff @(posedge clk) begin
      if (rst)       cnt_q <= '0;
      else if (wrap) cnt_q <= '0;
      else           cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/dws_word_latch.sv
module dws_word_latch #(
   parameter int unsigned WORD_W = 20
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [WORD_W-1:0] par_data,
   input  logic              width_sel,
   output logic [WORD_W-1:0] hold_data,
   output logic              hold_wide,
   output logic              cur_wide
);
   always_ff @(posedge clk) begin
      if (rst) begin
         hold_data <= '0;
         hold_wide <= 1'b0;
         cur_wide  <= 1'b0;
      end else if (load) begin
         hold_data <= par_data;
         hold_wide <= width_sel;
         cur_wide  <= hold_wide;
      end
   end
endmodule

// File: rtl/dws_shifter.sv
module dws_shifter #(
   parameter int unsigned GROUP_W = 10,
   parameter int unsigned GROUPS  = 2
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        load,
   input  logic [GROUP_W*GROUPS-1:0]   hold_data,
   input  logic                        hold_wide,
   output logic                        bit_out
);
   localparam int unsigned WORD_W = GROUP_W * GROUPS;

   logic [WORD_W-1:0] load_word;
   logic [WORD_W-1:0] sh_q;

   // The narrow word uses the topmost group and starts at the bottom of the register.
   generate
      if (GROUPS == 1) begin : g_single
         assign load_word = hold_data;
      end else begin : g_multi
         logic [WORD_W-1:0] narrow_word;
         assign narrow_word = {{(WORD_W-GROUP_W){1'b0}}, hold_data[WORD_W-1 -: GROUP_W]};
         assign load_word   = hold_wide ? hold_data : narrow_word;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)       sh_q <= '0;
      else if (load) sh_q <= load_word;
      else           sh_q <= {1'b0, sh_q[WORD_W-1:1]};
   end

   assign bit_out = sh_q[0];
endmodule

// File: rtl/dws_line_ctl.sv
module dws_line_ctl
   import dws_pkg::*;
(
   input  logic [1:0] oe,
   input  logic       data_bit,
   output logic       line
);
   line_mode_e mode;
   assign mode = line_mode_e'(oe);

   always_comb begin
      unique case (mode)
         LINE_LOW:  line = 1'b0;
         LINE_HIGH: line = 1'b1;
         default:   line = data_bit;
      endcase
   end
endmodule

// File: rtl/dws_serializer.sv
module dws_serializer
   import dws_pkg::*;
#(
   parameter int unsigned GROUP_W = 10,
   parameter int unsigned GROUPS  = 2
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      width_sel,
   input  logic [GROUP_W*GROUPS-1:0] par_data,
   input  logic [1:0]                oe,
   output logic                      ser_out,
   output logic                      word_strb
);
   localparam int unsigned WORD_W = GROUP_W * GROUPS;
   localparam int unsigned CNT_W  = cnt_bits(WORD_W);
   localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(GROUP_W - 1);
   localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(WORD_W - 1);

   generate
      if (GROUP_W < 2) begin : g_bad_group
         $error("GROUP_W must be at least 2");
      end
      if (GROUPS < 1) begin : g_bad_groups
         $error("GROUPS must be at least 1");
      end
   endgenerate

   logic              wrap;
   logic [WORD_W-1:0] hold_data;
   logic              hold_wide;
   logic              cur_wide;
   logic              data_bit;
   logic [CNT_W-1:0]  last_idx;

   assign last_idx  = cur_wide ? LAST_WIDE : LAST_NARROW;
   assign word_strb = wrap;

   dws_bit_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .last_idx (last_idx),
      .wrap     (wrap)
   );

   dws_word_latch #(.WORD_W(WORD_W)) u_latch (
      .clk       (clk),
      .rst       (rst),
      .load      (wrap),
      .par_data  (par_data),
      .width_sel (width_sel),
      .hold_data (hold_data),
      .hold_wide (hold_wide),
      .cur_wide  (cur_wide)
   );

   dws_shifter #(.GROUP_W(GROUP_W), .GROUPS(GROUPS)) u_shift (
      .clk       (clk),
      .rst       (rst),
      .load      (wrap),
      .hold_data (hold_data),
      .hold_wide (hold_wide),
      .bit_out   (data_bit)
   );

   dws_line_ctl u_line (
      .oe       (oe),
      .data_bit (data_bit),
      .line     (ser_out)
   );
endmodule

// File: rtl/dws_serializer_chk.sv
module dws_serializer_chk #(
   parameter int unsigned GROUP_W = 10,
   parameter int unsigned GROUPS  = 2
) (
   input logic       clk,
   input logic       rst,
   input logic [1:0] oe,
   input logic       ser_out,
   input logic       word_strb
);
   localparam int unsigned WORD_W = GROUP_W * GROUPS;
   localparam int unsigned GAP_W  = $clog2(WORD_W) + 2;

   logic [GAP_W-1:0] gap_q;
   logic             seen_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else if (word_strb) begin
         gap_q  <= '0;
         seen_q <= 1'b1;
      end else if (gap_q != {GAP_W{1'b1}}) begin
         gap_q  <= gap_q + 1'b1;
      end
   end

   // R9
   oe_low_chk: assert property (@(posedge clk) disable iff (rst)
      (oe == 2'b00) |-> !ser_out);
   // R9
   oe_high_chk: assert property (@(posedge clk) disable iff (rst)
      (oe == 2'b01) |-> ser_out);
   // R1
   first_word_chk: assert property (@(posedge clk) disable iff (rst)
      (word_strb && !seen_q) |-> (gap_q == GAP_W'(GROUP_W - 1)));
   // R2
   strb_spacing_chk: assert property (@(posedge clk) disable iff (rst)
      word_strb |-> (gap_q == GAP_W'(GROUP_W - 1) || gap_q == GAP_W'(WORD_W - 1)));
   // R3
   gap_bound_chk: assert property (@(posedge clk) disable iff (rst)
      !word_strb |-> (gap_q < GAP_W'(WORD_W - 1)));
endmodule

bind dws_serializer dws_serializer_chk #(.GROUP_W(GROUP_W), .GROUPS(GROUPS)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .oe        (oe),
   .ser_out   (ser_out),
   .word_strb (word_strb)
);

// File: tb/dws_serializer_bench.sv
module dws_serializer_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        width_sel = 1'b0;
   logic [19:0] par_data = '0;
   logic [1:0]  oe = 2'b10;
   logic        ser_out;
   logic        word_strb;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;
   string tag = "R1";

   // behavioural reference state
   bit cur_q[$];
   bit pend_q[$];
   bit pend_wide;
   int pos;

   always #10 clk = ~clk;

   dws_serializer u_dws_serializer (
      .clk (clk), .rst (rst), .width_sel (width_sel),
      .par_data (par_data), .oe (oe), .ser_out (ser_out), .word_strb (word_strb)
   );

   function automatic void fill(ref bit q[$], input logic [19:0] d, input bit wide);
      q.delete();
      if (wide) for (int k = 0; k < 20; k++) q.push_back(d[k]);   // R5
      else      for (int k = 0; k < 10; k++) q.push_back(d[10+k]); // R4, R6
   endfunction

   task automatic model_update();
      if (rst) begin                       // R1
         fill(cur_q, '0, 1'b0);
         fill(pend_q, '0, 1'b0);
         pend_wide = 1'b0;
         pos = 0;
      end else if (pos == cur_q.size() - 1) begin   // R7, R8
         cur_q = pend_q;
         fill(pend_q, par_data, width_sel);
         pend_wide = width_sel;
         pos = 0;
      end else begin
         pos++;
      end
   endtask

   task automatic compare();
      bit exp_strb;
      bit exp_ser;
      exp_strb = (pos == cur_q.size() - 1);
      if (oe == 2'b00)      exp_ser = 1'b0;   // R9
      else if (oe == 2'b01) exp_ser = 1'b1;   // R9
      else                  exp_ser = cur_q[pos];
      tests++;
      if (word_strb !== exp_strb) begin
         fails++;
         $display("FAIL %s word_strb actual %0b expected %0b", (cur_q.size() == 10) ? "R2" : "R3",
                  word_strb, exp_strb);
      end
      tests++;
      if (ser_out !== exp_ser) begin
         fails++;
         $display("FAIL %s ser_out actual %0b expected %0b", oe[1] ? tag : "R9", ser_out, exp_ser);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      model_update();
      @(negedge clk);
      compare();
   endtask

   initial begin
      tag = "R1";
      rst = 1'b1;
      repeat (3) tick();
      rst = 1'b0;
      width_sel = 1'b1;
      par_data = 20'hABCDE;
      repeat (12) tick();                          // R1 zero word then strobe at cycle 10

      tag = "R4";                                  // narrow traffic, R2 spacing
      width_sel = 1'b0;
      repeat (300) begin
         par_data = 20'($urandom());
         tick();
      end

      tag = "R6";                                  // narrow, lower lanes churn every cycle
      repeat (200) begin
         par_data[9:0] = 10'($urandom());
         if (word_strb) par_data[19:10] = 10'($urandom());
         tick();
      end

      tag = "R5";                                  // wide traffic, R3 spacing, R7 pipelining
      width_sel = 1'b1;
      repeat (400) begin
         par_data = 20'($urandom());
         tick();
      end

      tag = "R8";                                  // width toggles every cycle
      repeat (800) begin
         width_sel = 1'($urandom());
         par_data  = 20'($urandom());
         tick();
      end

      tag = "R9";                                  // enable codes during traffic
      for (int c = 0; c < 4; c++) begin
         oe = 2'(c);
         repeat (60) begin
            width_sel = 1'($urandom());
            par_data  = 20'($urandom());
            tick();
         end
      end

      tag = "R1";                                  // reset mid-word
      oe = 2'b11;
      rst = 1'b1;
      repeat (2) tick();
      rst = 1'b0;
      repeat (30) tick();

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: run did not complete");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule